// File: doc/BRIEF.md
# Tagged Receive Buffer with Fill Alarms

This block buffers the words that a Manchester bus decoder recovers, so that a register interface can read them later. Each word is nine bits wide. The low eight bits carry a received byte. The top bit is a marker that, together with a fixed low byte, flags three in-band events: the start of a packet, the end of a packet, and a half-bit slip. Because the stop delimiter arrives as a word in the buffer, the reader can find a frame boundary without an idle timer. When it sees a slip word, the reader drops the packet it is assembling. The block decodes the marker class of each word it reads out and presents it beside the word.

The block holds up to `DEPTH` words and reports how many it holds. It raises two sticky alarm flags. The level flag sets when the occupancy climbs to a programmable threshold. The full flag sets when the buffer becomes full. Each flag has a mask bit. A mask bit of 0 lets that flag drive the shared interrupt output. Software reads the status port to find the cause, and that read clears the flags. A word pushed while the buffer is full is lost.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset, level_o, rd_data_o, kind_o, status_o and irq_o are all zero.
- R2: The block returns words in the order it accepted them, with all nine bits unchanged. A pop issued in one cycle updates rd_data_o at that clock edge. rd_data_o then holds its value until the next pop.
- R3: A push while level_o equals DEPTH (16) is discarded. The level stays at DEPTH, and the word never appears at the output.
- R4: A pop while the buffer is empty loads rd_data_o with 0x000 and leaves level_o at 0.
- R5: level_o is the current occupancy. A push together with a pop on a buffer that is neither empty nor full leaves level_o unchanged.
- R6: kind_o classifies rd_data_o. 0x14D gives 1 (packet start), 0x126 gives 2 (packet end) and 0x100 gives 3 (slip). Every other word, including other words with bit 8 set, gives 0 (data).
- R7: status_o[0] (the level flag) sets one cycle after occupancy moves from below thresh_i to thresh_i or above, for a threshold from 1 to 15. It does not set again while occupancy stays at or above the threshold. With thresh_i equal to 0 it never sets.
- R8: status_o[1] (the full flag) sets one cycle after occupancy reaches DEPTH.
- R9: A set flag stays set until a cycle with stat_rd_i high. status_o shows the flags during that cycle, and they clear at its closing edge. A set event in that same cycle wins.
- R10: irq_o is high exactly when a set flag has its mask bit at 0. mask_i[0] gates the level flag and mask_i[1] gates the full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write strobe from the decoder |
| push_data_i | input | 9 | Word to store, bit 8 is the marker |
| pop_i | input | 1 | Read strobe |
| rd_data_o | output | 9 | Last word read out |
| kind_o | output | 2 | Marker class of rd_data_o |
| level_o | output | 5 | Occupancy, 0 to DEPTH |
| thresh_i | input | 4 | Level alarm threshold, 0 disables it |
| mask_i | input | 2 | Alarm masks, 0 enables a flag onto irq_o |
| stat_rd_i | input | 1 | Status read strobe, clears the flags |
| status_o | output | 2 | Sticky flags: bit 0 level, bit 1 full |
| irq_o | output | 1 | Shared interrupt |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that thresh_i stays constant while the level flag is under observation, because a change of threshold can move the alarm condition with no change in occupancy. The stimulus drives all inputs on the falling edge. It changes thresh_i only while the flag is about to be cleared or is not being checked. It never issues a status read in the cycle in which a set event is expected, so each flag check sees one cause at a time.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;
  localparam int unsigned WORD_W = 9;
  localparam logic [WORD_W-1:0] TAG_SOP  = 9'h14D;
  localparam logic [WORD_W-1:0] TAG_EOP  = 9'h126;
  localparam logic [WORD_W-1:0] TAG_SLIP = 9'h100;
  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_SOP  = 2'd1,
    KIND_EOP  = 2'd2,
    KIND_SLIP = 2'd3
  } kind_e;
endpackage

// File: rtl/rx_tag_store.sv
module rx_tag_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 9,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic [WORD_W-1:0] rd_q;
  logic              push_ok, pop_ok;

  assign push_ok = push_i && (count_q != CNT_W'(DEPTH)); // full drops, even with a pop
  assign pop_ok  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      rd_q     <= '0;
    end else begin
      if (push_ok)
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      if (pop_i)
        rd_q <= pop_ok ? mem_q[rd_ptr_q] : '0;
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  assign rd_data_o = rd_q;
  assign count_o   = count_q;
endmodule

// File: rtl/rx_tag_alarm.sv
module rx_tag_alarm #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned THR_W = 4,
  parameter int unsigned N_FLG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             stat_rd_i,
  output logic [N_FLG-1:0] flags_o
);
  logic [N_FLG-1:0] cond, cond_q, set_ev;

  assign cond[0] = (thresh_i != '0) && (count_i >= CNT_W'(thresh_i));
  assign cond[1] = (count_i == CNT_W'(DEPTH));
  assign set_ev  = cond & ~cond_q; // rising crossing only

  for (genvar i = 0; i < N_FLG; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cond_q[i] <= 1'b0;
        flag_q    <= 1'b0;
      end else begin
        cond_q[i] <= cond[i];
        flag_q    <= set_ev[i] | (flag_q & ~stat_rd_i);
      end
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/rx_tag_classify.sv
module rx_tag_classify
  import rx_tag_fifo_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output kind_e             kind_o
);
  always_comb begin
    unique case (word_i)
      TAG_SOP:  kind_o = KIND_SOP;
      TAG_EOP:  kind_o = KIND_EOP;
      TAG_SLIP: kind_o = KIND_SLIP;
      default:  kind_o = KIND_DATA;
    endcase
  end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rx_tag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_W = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [1:0]        kind_o,
  output logic [CNT_W-1:0]  level_o,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic [1:0]        mask_i,
  input  logic              stat_rd_i,
  output logic [1:0]        status_o,
  output logic              irq_o
);
  kind_e kind;

  rx_tag_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
    .clk_i, .rst_ni, .push_i, .push_data_i, .pop_i,
    .rd_data_o, .count_o(level_o)
  );

  rx_tag_alarm #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W), .N_FLG(2)) u_alarm (
    .clk_i, .rst_ni, .count_i(level_o), .thresh_i, .stat_rd_i, .flags_o(status_o)
  );

  rx_tag_classify u_cls (.word_i(rd_data_o), .kind_o(kind));

  assign kind_o = kind;
  assign irq_o  = |(status_o & ~mask_i);
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_W = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic [8:0]       push_data_i,
  input logic             pop_i,
  input logic [8:0]       rd_data_o,
  input logic [1:0]       kind_o,
  input logic [CNT_W-1:0] level_o,
  input logic [THR_W-1:0] thresh_i,
  input logic [1:0]       mask_i,
  input logic             stat_rd_i,
  input logic [1:0]       status_o,
  input logic             irq_o
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CNT_W'(DEPTH));

  a_r3_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == CNT_W'(DEPTH) && push_i && !pop_i) |=> $stable(level_o));

  a_r4_empty_pop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0 && pop_i && !push_i) |=> (level_o == '0 && rd_data_o == '0));

  a_r2_hold_without_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(rd_data_o));

  a_r5_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && level_o < CNT_W'(DEPTH)) |=> level_o == $past(level_o) + CNT_W'(1));

  a_r6_data_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[8] |-> kind_o == 2'd0);

  a_r9_sticky_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !stat_rd_i) |=> status_o[0]);

  a_r9_sticky_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !stat_rd_i) |=> status_o[1]);

  a_r8_full_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == CNT_W'(DEPTH) && $past(level_o) != CNT_W'(DEPTH)) |=> status_o[1]);

  a_r10_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 2'b11) |-> !irq_o);

  a_r7_disabled_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i == '0 && !status_o[0]) |=> !status_o[0]);

  logic unused_ok;
  assign unused_ok = ^push_data_i;
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
  .pop_i(pop_i), .rd_data_o(rd_data_o), .kind_o(kind_o), .level_o(level_o),
  .thresh_i(thresh_i), .mask_i(mask_i), .stat_rd_i(stat_rd_i),
  .status_o(status_o), .irq_o(irq_o)
);

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0;
  logic [8:0] push_data_i = '0;
  logic       pop_i = 1'b0;
  logic [8:0] rd_data_o;
  logic [1:0] kind_o;
  logic [4:0] level_o;
  logic [3:0] thresh_i = '0;
  logic [1:0] mask_i = 2'b11;
  logic       stat_rd_i = 1'b0;
  logic [1:0] status_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_tag_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .rd_data_o(rd_data_o), .kind_o(kind_o), .level_o(level_o),
    .thresh_i(thresh_i), .mask_i(mask_i), .stat_rd_i(stat_rd_i),
    .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [8:0] w);
    if (w == 9'h14D) return 1;
    if (w == 9'h126) return 2;
    if (w == 9'h100) return 3;
    return 0;
  endfunction

  // scoreboard model
  logic [8:0] sb_q[$];
  logic [8:0] exp_word = '0;
  bit         pend = 0;
  bit         pend_empty = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      int sz;
      sz = sb_q.size();
      pend = pop_i;
      if (pop_i) begin
        pend_empty = (sz == 0);
        exp_word = (sz == 0) ? 9'h000 : sb_q.pop_front();
      end
      if (push_i && sz < DEPTH) sb_q.push_back(push_data_i);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (pend && rst_n) begin
      pend = 0;
      if (pend_empty) chk("R4 empty pop word", rd_data_o, 0);
      else            chk("R2 order", rd_data_o, exp_word);
      chk("R6 kind", kind_o, kind_of(exp_word));
    end
  end

  task automatic push(input logic [8:0] d);
    @(negedge clk); push_i = 1'b1; push_data_i = d;
    @(negedge clk); push_i = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pop_i = 1'b1;
    end
    @(negedge clk); pop_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic stat_read();
    @(negedge clk); stat_rd_i = 1'b1;
    @(negedge clk); stat_rd_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", level_o, 0);
    chk("R1 rd_data", rd_data_o, 0);
    chk("R1 kind", kind_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R6 a tagged packet
    push(9'h14D); push(9'h041); push(9'h0FF); push(9'h155); push(9'h100); push(9'h126);
    chk("R5 level", level_o, 6);
    pop_n(6);
    chk("R5 level drained", level_o, 0);
    @(negedge clk);
    chk("R2 hold", rd_data_o, 9'h126);

    // R4 empty pop
    pop_n(1);
    chk("R4 level", level_o, 0);

    // R7 level alarm
    thresh_i = 4'd3; mask_i = 2'b10;
    push(9'h011); push(9'h022);
    @(negedge clk);
    chk("R7 below threshold", status_o, 0);
    chk("R10 no irq", irq_o, 0);
    push(9'h033);
    @(negedge clk);
    chk("R7 level set", status_o, 2'b01);
    chk("R10 level irq", irq_o, 1);
    repeat (3) @(negedge clk);
    chk("R9 level sticky", status_o, 2'b01);
    @(negedge clk); stat_rd_i = 1'b1;
    chk("R9 visible in read", status_o, 2'b01);
    @(negedge clk); stat_rd_i = 1'b0;
    chk("R9 cleared", status_o, 0);
    chk("R10 irq dropped", irq_o, 0);

    // R8 full alarm, level stays above threshold
    for (int i = 0; i < 13; i++) push(9'(9'h080 + i));
    chk("R5 full level", level_o, 16);
    @(negedge clk);
    chk("R8 full set", status_o, 2'b10);
    chk("R10 full masked", irq_o, 0);
    mask_i = 2'b00;
    @(negedge clk);
    chk("R10 full unmasked", irq_o, 1);

    // R3 push while full
    push(9'h1AA);
    chk("R3 level held", level_o, 16);
    @(negedge clk); push_i = 1'b1; push_data_i = 9'h1BB; pop_i = 1'b1;
    @(negedge clk); push_i = 1'b0; pop_i = 1'b0;
    chk("R3 full push with pop", level_o, 15);
    pop_n(15);
    chk("R3 drained", level_o, 0);

    // R7 threshold 0 disables
    thresh_i = 4'd0;
    stat_read();
    chk("R9 full cleared", status_o, 0);
    for (int i = 0; i < 5; i++) push(9'(9'h0C0 + i));
    @(negedge clk);
    chk("R7 disabled", status_o, 0);

    // R5 simultaneous push and pop
    @(negedge clk); push_i = 1'b1; push_data_i = 9'h0DD; pop_i = 1'b1;
    @(negedge clk); push_i = 1'b0; pop_i = 1'b0;
    chk("R5 push+pop level", level_o, 5);
    pop_n(5);
    chk("R5 final level", level_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule